// File: doc/BRIEF.md
# Mode-Switched Programmable Frequency Divider

This block sits between two prescaled RF inputs and a phase comparator. It picks one of the two inputs, counts its rising ticks, and issues a single-cycle pulse each time the count reaches a programmed division ratio. A 16-bit divisor word and two mode bits set both the ratio and the input. In the wide mode, the high-band input is used and the ratio is doubled. The two low-band modes take the divisor either from the whole word or from its upper twelve bits. An inhibit flag freezes the divider.

Both RF inputs arrive as tick strobes that are synchronous to the block clock. A tick counts when the selected strobe is high at a clock edge. A three-state machine controls the counter:
- ST_LOAD captures the ratio and the input selection, then moves to ST_RUN, or to ST_HALT if inhibit is high.
- ST_RUN counts ticks and moves to ST_HALT when inhibit rises.
- ST_HALT holds the counter at zero and returns to ST_LOAD when inhibit falls.

Reset places the machine in ST_LOAD. At each terminal count the ratio and the selection are captured again from the live inputs, so a change only takes effect on a period boundary.

Top module: `prog_freq_divider`

## Requirements
- R1: With `sel_wide`=1, only `rf_hi_tick` is counted and the period is 2×`div_word` ticks; `range_hi` has no effect in this mode.
- R2: With `sel_wide`=0 and `range_hi`=1, only `rf_lo_tick` is counted and the period is `div_word` ticks.
- R3: With `sel_wide`=0 and `range_hi`=0, only `rf_lo_tick` is counted and the period is `div_word[15:4]` ticks; bits 3..0 have no effect.
- R4: A setting below the floor of its mode is raised to that floor. The floor is 272 for the two modes that use the full word (before doubling) and 4 for the upper-bits mode.
- R5: A change to the word or the mode bits affects only the periods that start after the next terminal count; the period already running completes with the old ratio and the old input.
- R6: `div_pulse` is high for exactly one clock cycle. It rises in the cycle after the clock edge that samples the terminal tick.
- R7: While `inhibit` is high, no pulse is produced, `div_valid` is low and ticks are not counted. After `inhibit` falls, ticks sampled on the first two clock edges are ignored, and counting restarts from zero with the current word and mode.
- R8: A synchronous active-high `rst` clears `div_pulse` and `div_valid`. The first clock edge after release captures the configuration, and counting starts from zero.
- R9: Ticks on the input that the active mode does not select never change the period.
- R10: `div_valid` is high in every cycle in which the divider is counting, starting one cycle after the configuration is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | 16 | Divisor setting |
| sel_wide | input | 1 | 1: high-band input, doubled ratio |
| range_hi | input | 1 | With sel_wide=0: 1 full-word low-band, 0 upper-bits low-band |
| inhibit | input | 1 | Stops the divider |
| rf_hi_tick | input | 1 | High-band prescaled tick strobe |
| rf_lo_tick | input | 1 | Low-band prescaled tick strobe |
| div_pulse | output | 1 | One-cycle pulse at terminal count |
| div_valid | output | 1 | Divider is counting |

## Verification
The hardest case to reach is a mode change that also switches the input in the middle of a period. The running period has to finish on the old input and ratio, and the next one must start on the new input without losing or gaining a tick.

The stimulus runs in three-cycle tick slots:
- a tick on the unselected input alone;
- then a tick on both inputs;
- then an idle cycle.

A terminal tick therefore always falls just before an idle cycle. This lets the scoreboard switch its notion of the active input exactly at the pulse, while the unselected input still sees twice as many ticks as the selected one. Configuration is rewritten just after each pulse, so the first period of every phase is expected to carry the previous ratio.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } div_state_t;

endpackage

// File: rtl/pfd_ratio_calc.sv
module pfd_ratio_calc #(
    parameter int W          = 16,
    parameter int SHIFT      = 4,
    parameter int MIN_WIDE   = 272,
    parameter int MIN_NARROW = 4
) (
    input  logic [W-1:0] word,
    input  logic         sel_wide,
    input  logic         range_hi,
    output logic [W:0]   ratio
);

    logic [W-1:0] base;
    logic [W-1:0] floor_v;
    logic [W-1:0] clamped;

    always_comb begin
        if (sel_wide || range_hi) begin
            base    = word;
            floor_v = W'(MIN_WIDE);
        end else begin
            base    = word >> SHIFT;
            floor_v = W'(MIN_NARROW);
        end
        clamped = (base < floor_v) ? floor_v : base;
        ratio   = sel_wide ? {clamped, 1'b0} : {1'b0, clamped};
    end

endmodule

// File: rtl/pfd_tick_gate.sv
module pfd_tick_gate (
    input  logic use_hi,
    input  logic inhibit,
    input  logic in_hi,
    input  logic in_lo,
    output logic tick
);

    logic picked;

    always_comb begin
        picked = use_hi ? in_hi : in_lo;
        tick   = picked & ~inhibit;
    end

endmodule

// File: rtl/prog_freq_divider.sv
module prog_freq_divider #(
    parameter int W          = 16,
    parameter int SHIFT      = 4,
    parameter int MIN_WIDE   = 272,
    parameter int MIN_NARROW = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div_word,
    input  logic         sel_wide,
    input  logic         range_hi,
    input  logic         inhibit,
    input  logic         rf_hi_tick,
    input  logic         rf_lo_tick,
    output logic         div_pulse,
    output logic         div_valid
);
    import pfd_pkg::*;

    localparam int CW = W + 1;

    div_state_t    state_q, state_nxt;
    logic [CW-1:0] ratio_now;
    logic [CW-1:0] ratio_q;
    logic [CW-1:0] cnt_q;
    logic          sel_q;
    logic          tick;
    logic          term;

    pfd_ratio_calc #(
        .W(W), .SHIFT(SHIFT), .MIN_WIDE(MIN_WIDE), .MIN_NARROW(MIN_NARROW)
    ) u_ratio (
        .word     (div_word),
        .sel_wide (sel_wide),
        .range_hi (range_hi),
        .ratio    (ratio_now)
    );

    pfd_tick_gate u_gate (
        .use_hi  (sel_q),
        .inhibit (inhibit),
        .in_hi   (rf_hi_tick),
        .in_lo   (rf_lo_tick),
        .tick    (tick)
    );

    // next-state decode
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_LOAD: state_nxt = inhibit ? ST_HALT : ST_RUN;
            ST_RUN:  state_nxt = inhibit ? ST_HALT : ST_RUN;
            ST_HALT: state_nxt = inhibit ? ST_HALT : ST_LOAD;
            default: state_nxt = ST_LOAD;
        endcase
    end

    assign term = (state_q == ST_RUN) && tick && (cnt_q == ratio_q - CW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOAD;
        else     state_q <= state_nxt;
    end

    // counter and captured configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= CW'(MIN_NARROW);
            sel_q   <= 1'b0;
        end else begin
            if (state_q == ST_LOAD || term) begin
                ratio_q <= ratio_now;
                sel_q   <= sel_wide;
            end
            if (state_q != ST_RUN)  cnt_q <= '0;
            else if (term)          cnt_q <= '0;
            else if (tick)          cnt_q <= cnt_q + CW'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            div_pulse <= 1'b0;
            div_valid <= 1'b0;
        end else begin
            div_pulse <= term;
            div_valid <= (state_nxt == ST_RUN);
        end
    end

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    assert_pulse_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(tick));

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |-> (!div_pulse && !div_valid));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (cnt_q < ratio_q));

    assert_ratio_floor_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (ratio_q >= CW'(MIN_NARROW)));

    assert_config_held_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && !$past(term))
            |-> ($stable(ratio_q) && $stable(sel_q)));

endmodule

// File: tb/tb_prog_freq_divider.sv
module tb_prog_freq_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] div_word = 16'd300;
    logic        sel_wide = 1'b0;
    logic        range_hi = 1'b1;
    logic        inhibit = 1'b0;
    logic        rf_hi_tick = 1'b0;
    logic        rf_lo_tick = 1'b0;
    logic        div_pulse;
    logic        div_valid;

    int    n_checks = 0;
    int    n_err = 0;
    int    exp_q[$];
    string tag_q[$];
    int    tick_cnt = 0;
    int    pulses_seen = 0;
    int    target = 0;
    int    cur = 0;
    bit    act_hf = 1'b0;
    bit    pend_hf = 1'b0;
    bit    inh_phase = 1'b0;
    bit    last_p = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    prog_freq_divider dut (
        .clk(clk), .rst(rst), .div_word(div_word), .sel_wide(sel_wide),
        .range_hi(range_hi), .inhibit(inhibit), .rf_hi_tick(rf_hi_tick),
        .rf_lo_tick(rf_lo_tick), .div_pulse(div_pulse), .div_valid(div_valid)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int calc(logic [15:0] w, bit hi, bit lo);
        int b;
        if (hi || lo) begin
            b = (w < 272) ? 272 : int'(w);
        end else begin
            b = int'(w[15:4]);
            if (b < 4) b = 4;
        end
        return hi ? 2 * b : b;
    endfunction

    // sel_v goes to the input the bench treats as selected, other_v to the rest (R9)
    task automatic drive(bit sel_v, bit other_v);
        if (act_hf) begin rf_hi_tick = sel_v;   rf_lo_tick = other_v; end
        else        begin rf_lo_tick = sel_v;   rf_hi_tick = other_v; end
    endtask

    task automatic slot();
        @(posedge clk); #1 drive(1'b0, 1'b1);
        @(posedge clk); #1 drive(1'b1, 1'b1);
        @(posedge clk); #1 drive(1'b0, 1'b0);
    endtask

    task automatic phase(logic [15:0] w, bit hi, bit lo, int n, string tag);
        div_word = w; sel_wide = hi; range_hi = lo; pend_hf = hi;
        exp_q.push_back(cur); tag_q.push_back("R5");
        cur = calc(w, hi, lo);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(cur); tag_q.push_back(tag);
        end
        target += n + 1;
        while (pulses_seen < target) slot();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (last_p) check(div_pulse == 1'b0, "R6", int'(div_pulse), 0);
            last_p = div_pulse;
            if (div_pulse) begin
                if (inh_phase) begin
                    check(1'b0, "R7", 1, 0);
                end else if (exp_q.size() == 0) begin
                    check(1'b0, "R5", tick_cnt, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(tick_cnt == e, t, tick_cnt, e);
                end
                pulses_seen++;
                tick_cnt = 0;
                act_hf = pend_hf;
            end
            if (!inh_phase && (act_hf ? rf_hi_tick : rf_lo_tick)) tick_cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual %0d expected %0d", pulses_seen, target);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(div_pulse == 1'b0, "R8", int'(div_pulse), 0);
        check(div_valid == 1'b0, "R8", int'(div_valid), 0);
        @(posedge clk); #1 rst = 1'b0;
        cur = calc(16'd300, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(div_valid == 1'b1, "R10", int'(div_valid), 1);

        phase(16'd300,  1'b0, 1'b1, 1, "R2");
        phase(16'd300,  1'b1, 1'b0, 2, "R1 R9");
        phase(16'h0123, 1'b1, 1'b1, 1, "R1");
        phase(16'd100,  1'b0, 1'b1, 1, "R4");
        phase(16'h123F, 1'b0, 1'b0, 2, "R3");
        phase(16'h0025, 1'b0, 1'b0, 2, "R4");
        phase(16'd5,    1'b1, 1'b0, 1, "R4");
        phase(16'h00A7, 1'b0, 1'b0, 1, "R3");

        // R7: inhibit mid-period
        inhibit = 1'b1; inh_phase = 1'b1;
        repeat (40) slot();
        @(negedge clk);
        check(pulses_seen == target, "R7", pulses_seen, target);
        check(div_valid == 1'b0, "R7", int'(div_valid), 0);
        @(posedge clk); #1 inhibit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        tick_cnt = 0; act_hf = pend_hf; inh_phase = 1'b0;
        @(negedge clk);
        check(div_valid == 1'b1, "R10", int'(div_valid), 1);
        for (int i = 0; i < 2; i++) begin
            exp_q.push_back(cur); tag_q.push_back("R7");
        end
        target += 2;
        while (pulses_seen < target) slot();

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule